// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Status Flags

This block takes one asynchronous serial input and recovers characters from it. It uses an oversampling tick, by default sixteen ticks per bit period. The frame format comes from a line-format byte that uses the same encoding as the companion transmitter: character length, parity enable, even/odd choice and stick parity. Each received character goes into a single holding register. A status byte reports whether a character is waiting, plus sticky flags for overrun, parity error, framing error, break and an overall error summary.

Software or a controlling state machine reads the character with a one-cycle data strobe, which clears the ready flag. It reads the status with a separate one-cycle status strobe, which clears the error flags. The line is passed through a synchronizer first. A start edge is confirmed at the middle of the start bit, and every later bit is sampled one full bit period after the previous sample.

Top module: `uart_rx_line`

## Requirements
- R1: While reset is high and in the cycle after it, the data output and the whole status byte are zero; status bits 5 and 6 always read zero.
- R2: Format bits [1:0] pick 5, 6, 7 or 8 data bits (00 to 11), received LSB first. Unused upper bits of the data output read zero. Status bit 0 (ready) is set in the cycle after a frame's stop bit has been sampled.
- R3: A data-read strobe clears status bit 0 and leaves the data output unchanged. A frame completing in the same cycle keeps bit 0 set.
- R4: A frame that completes while bit 0 is still set and no data read is pending sets status bit 1 (overrun). The new character replaces the old one.
- R5: Format bit 3 enables a parity bit after the data. With bit 5 clear, bit 4 = 1 selects even parity and bit 4 = 0 selects odd parity. With bit 5 set, the parity bit must be the inverse of bit 4. A mismatch sets status bit 2.
- R6: A low level sampled at the stop-bit position sets status bit 3 (framing error), unless the frame is a break.
- R7: A frame whose start, data, parity and stop samples are all low is a break. It loads 0x00, sets bits 0 and 4, and sets neither bit 2 nor bit 3. No further frame is taken until the line has been seen high.
- R8: A low pulse that is high again at the eighth tick after detection is ignored, and the status does not change.
- R9: Status bit 7 is set exactly when any of bits 1 to 4 is set. A status-read strobe clears bits 1 to 4 and bit 7 and leaves bit 0 as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial_i | input | 1 | Asynchronous serial line, idle high |
| line_cfg_i | input | 8 | Line format: [1:0] length, [3] parity enable, [4] even, [5] stick |
| os_tick_i | input | 1 | Oversampling tick, one clock wide |
| rd_data_i | input | 1 | Data-read strobe |
| rd_stat_i | input | 1 | Status-read strobe |
| rx_data_o | output | 8 | Last received character |
| line_stat_o | output | 8 | Status: [0] ready, [1] overrun, [2] parity, [3] framing, [4] break, [7] summary |

## Verification
The hardest condition to reach from the ports is a break that lasts well beyond one frame. It must be reported once, and the receiver must then recover cleanly. The stimulus holds the line low for more than a full frame and checks the flag set. It then reads data and status while the line is still low, keeps the line low for another frame time to confirm nothing new arrives, and then releases the line and sends an ordinary character. A separate short low pulse that ends before mid-start exercises the glitch rejection.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int STAT_READY = 0;
    localparam int STAT_OVR   = 1;
    localparam int STAT_PAR   = 2;
    localparam int STAT_FRM   = 3;
    localparam int STAT_BRK   = 4;
    localparam int STAT_SUM   = 7;

    // bit layout shared with the transmitter's format byte
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len_sel;
    } line_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_frame_t;

    function automatic logic [3:0] data_bits(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    // data is already zero above the character length
    function automatic logic expected_parity(input logic [7:0] d, input line_fmt_t f);
        if (f.stick) return ~f.even;
        return f.even ? ^d : ~^d;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= 1'b1;
                else     stage_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b1;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      line_i,
    input  line_fmt_t fmt_i,
    output logic      done_o,
    output rx_frame_t frame_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic             par_bad;
    logic             any_one;
    logic [3:0]       nbits;
    logic             last_bit;
    logic             is_brk;

    assign nbits    = data_bits(fmt_i.len_sel);
    assign last_bit = ({1'b0, bit_idx} == nbits - 4'd1);
    assign is_brk   = !any_one && !line_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bad <= 1'b0;
            any_one <= 1'b0;
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                case (state)
                    ST_IDLE: begin
                        if (!line_i) begin
                            state <= ST_START;
                            cnt   <= CNT_W'(1);   // detection tick counts as the first
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!line_i) begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_bad <= 1'b0;
                                any_one <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= line_i;
                            any_one        <= any_one | line_i;
                            if (last_bit) state <= fmt_i.par_en ? ST_PAR : ST_STOP;
                            else          bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_bad <= (line_i != expected_parity(shreg, fmt_i));
                            any_one <= any_one | line_i;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt             <= '0;
                            done_o          <= 1'b1;
                            frame_o.data    <= shreg;
                            frame_o.brk     <= is_brk;
                            frame_o.frm_err <= !line_i && !is_brk;
                            frame_o.par_err <= fmt_i.par_en && par_bad && !is_brk;
                            state           <= line_i ? ST_IDLE : ST_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (line_i) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done_i,
    input  rx_frame_t  frame_i,
    input  logic       rd_data_i,
    input  logic       rd_stat_i,
    output logic [7:0] data_o,
    output logic [7:0] stat_o
);
    logic ready_q, ovr_q, perr_q, ferr_q, brk_q, sum_q;
    logic set_ovr, set_par, set_frm, set_brk;

    assign set_ovr = done_i && ready_q && !rd_data_i;
    assign set_par = done_i && frame_i.par_err;
    assign set_frm = done_i && frame_i.frm_err;
    assign set_brk = done_i && frame_i.brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            brk_q   <= 1'b0;
            sum_q   <= 1'b0;
        end else begin
            if (done_i) data_o <= frame_i.data;
            if (done_i)         ready_q <= 1'b1;
            else if (rd_data_i) ready_q <= 1'b0;
            ovr_q  <= (ovr_q  && !rd_stat_i) || set_ovr;
            perr_q <= (perr_q && !rd_stat_i) || set_par;
            ferr_q <= (ferr_q && !rd_stat_i) || set_frm;
            brk_q  <= (brk_q  && !rd_stat_i) || set_brk;
            sum_q  <= (sum_q  && !rd_stat_i) || set_ovr || set_par || set_frm || set_brk;
        end
    end

    always_comb begin
        stat_o             = '0;
        stat_o[STAT_READY] = ready_q;
        stat_o[STAT_OVR]   = ovr_q;
        stat_o[STAT_PAR]   = perr_q;
        stat_o[STAT_FRM]   = ferr_q;
        stat_o[STAT_BRK]   = brk_q;
        stat_o[STAT_SUM]   = sum_q;
    end
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_serial_i,
    input  logic [7:0] line_cfg_i,
    input  logic       os_tick_i,
    input  logic       rd_data_i,
    input  logic       rd_stat_i,
    output logic [7:0] rx_data_o,
    output logic [7:0] line_stat_o
);
    line_fmt_t fmt;
    logic      line_sync;
    logic      frame_done;
    rx_frame_t frame;
    logic      cfg_unused;

    assign fmt        = line_fmt_t'(line_cfg_i[5:0]);
    assign cfg_unused = ^{line_cfg_i[7:6], fmt.two_stop};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_serial_i),
        .dout (line_sync)
    );

    uart_rx_deframer #(.OVERSAMPLE(OVERSAMPLE)) deframer_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (os_tick_i),
        .line_i  (line_sync),
        .fmt_i   (fmt),
        .done_o  (frame_done),
        .frame_o (frame)
    );

    uart_rx_hold hold_i (
        .clk       (clk),
        .rst       (rst),
        .done_i    (frame_done),
        .frame_i   (frame),
        .rd_data_i (rd_data_i),
        .rd_stat_i (rd_stat_i),
        .data_o    (rx_data_o),
        .stat_o    (line_stat_o)
    );
endmodule

// File: rtl/uart_rx_line_chk.sv
module uart_rx_line_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_data_i,
    input logic       rd_stat_i,
    input logic       frame_done,
    input logic [7:0] stat,
    input logic [7:0] data
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stat == 8'h00 && data == 8'h00));

    // R2
    done_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> stat[0]);

    // R3
    read_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_i && !frame_done) |=> !stat[0]);

    // R4
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && stat[0] && !rd_data_i) |=> stat[1]);

    // R7
    break_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[4]) |-> (data == 8'h00 && !stat[3] && !stat[2]));

    // R9
    summary_match_chk: assert property (@(posedge clk) disable iff (rst)
        stat[7] == (|stat[4:1]));

    // R9
    status_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stat_i && !frame_done) |=> (stat[4:1] == 4'h0 && !stat[7]));
endmodule

bind uart_rx_line uart_rx_line_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_data_i  (rd_data_i),
    .rd_stat_i  (rd_stat_i),
    .frame_done (frame_done),
    .stat       (line_stat_o),
    .data       (rx_data_o)
);

// File: tb/uart_rx_line_tb_top.sv
module uart_rx_line_tb_top;
    localparam int BIT_CLKS = 32;   // 16 ticks, one every other clock

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [7:0] cfg = 8'h03;
    logic       tick = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_stat = 1'b0;
    logic [7:0] dout;
    logic [7:0] stat;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    uart_rx_line dut_i (
        .clk         (clk),
        .rst         (rst),
        .rx_serial_i (rxd),
        .line_cfg_i  (cfg),
        .os_tick_i   (tick),
        .rd_data_i   (rd_data),
        .rd_stat_i   (rd_stat),
        .rx_data_o   (dout),
        .line_stat_o (stat)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tick <= ~tick;
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic [7:0] c);
        logic [7:0] m;
        m = d & ((8'h01 << (5 + c[1:0])) - 8'h01);
        if (c[5]) return ~c[4];
        return c[4] ? ^m : ~^m;
    endfunction

    task automatic drive_bit(input logic lvl);
        rxd = lvl;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic flip_par, input logic stop_lvl);
        drive_bit(1'b0);
        for (int i = 0; i < 5 + int'(cfg[1:0]); i++) drive_bit(d[i]);
        if (cfg[3]) drive_bit(par_of(d, cfg) ^ flip_par);
        drive_bit(stop_lvl);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic pulse_data();
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_stat();
        rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 data", dout, 8'h00);
        check("R1 stat", stat, 8'h00);
    endtask

    task automatic t_lengths();
        cfg = 8'h03; send(8'hA5, 1'b0, 1'b1);
        check("R2 8bit data", dout, 8'hA5);
        check("R2 8bit stat", stat, 8'h01);
        pulse_data();
        check("R3 ready cleared", stat, 8'h00);
        check("R3 data kept", dout, 8'hA5);
        cfg = 8'h00; send(8'hFF, 1'b0, 1'b1);
        check("R2 5bit data", dout, 8'h1F);
        pulse_data();
        cfg = 8'h01; send(8'hEA, 1'b0, 1'b1);
        check("R2 6bit data", dout, 8'h2A);
        pulse_data();
    endtask

    task automatic t_parity();
        cfg = 8'h1A; send(8'h5A, 1'b0, 1'b1);
        check("R5 even ok", stat, 8'h01);
        check("R5 even data", dout, 8'h5A);
        pulse_data();
        cfg = 8'h0A; send(8'h33, 1'b1, 1'b1);
        check("R5 odd bad", stat, 8'h85);
        pulse_stat();
        check("R9 read clears errors keeps ready", stat, 8'h01);
        pulse_data();
        cfg = 8'h3B; send(8'h81, 1'b0, 1'b1);
        check("R5 stick ok", stat, 8'h01);
        pulse_data();
        send(8'h81, 1'b1, 1'b1);
        check("R5 stick bad", stat, 8'h85);
        pulse_data(); pulse_stat();
    endtask

    task automatic t_overrun();
        cfg = 8'h03;
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        check("R4 overrun stat", stat, 8'h83);
        check("R4 newest data", dout, 8'h22);
        pulse_data(); pulse_stat();
        check("R9 all cleared", stat, 8'h00);
    endtask

    task automatic t_framing();
        cfg = 8'h03; send(8'h55, 1'b0, 1'b0);
        check("R6 framing stat", stat, 8'h89);
        check("R6 framing data", dout, 8'h55);
        pulse_data(); pulse_stat();
    endtask

    task automatic t_break();
        cfg = 8'h0B;   // 8 data bits plus odd parity: 11 low bits make the frame
        send(8'h00, 1'b0, 1'b1);
        pulse_data();
        repeat (13) drive_bit(1'b0);
        check("R7 break data", dout, 8'h00);
        check("R7 break stat", stat, 8'h91);
        pulse_data(); pulse_stat();
        repeat (12) drive_bit(1'b0);
        check("R7 single report", stat, 8'h00);
        drive_bit(1'b1); drive_bit(1'b1);
        send(8'h3C, 1'b0, 1'b1);
        check("R7 recovery data", dout, 8'h3C);
        check("R7 recovery stat", stat, 8'h01);
        pulse_data();
    endtask

    task automatic t_glitch();
        cfg = 8'h03;
        rxd = 1'b0; repeat (6) @(negedge clk);
        rxd = 1'b1; repeat (4 * BIT_CLKS) @(negedge clk);
        check("R8 glitch ignored", stat, 8'h00);
        send(8'hC3, 1'b0, 1'b1);
        check("R8 frame after glitch", dout, 8'hC3);
        pulse_data();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        repeat (2 * BIT_CLKS) @(negedge clk);
        t_lengths();
        t_parity();
        t_overrun();
        t_framing();
        t_break();
        t_glitch();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule